// File: doc/BRIEF.md
# Multiplexed Bidirectional GPIO Port

This block is an eight-pin general-purpose I/O port whose pins can be taken over by other functions on the chip. Software drives it through a small register bus. One register holds the per-pin direction. One holds the output latch. Reading the third gives the live pin levels after synchronization. Each pad gets an output value and an output enable from the block, and each pad returns its level to the block.

Ownership of each pin depends on the operating mode and two configuration inputs. In either external-memory mode, the whole byte belongs to the external address/data bus unless the memory controller's bus-off bit is set. In single-chip mode, the lowest three pins can become the strobe inputs of a parallel slave port. Pin 7 can carry the output of a capture/compare/PWM timer. Any pin not claimed by one of these functions falls back to ordinary I/O.

The register bus is a plain single-cycle interface with no back-pressure. A write is taken on the clock edge where `reg_we` is high. Read data is a combinational function of `reg_addr` and is always valid. The override signals and pad signals carry no handshake either: they are level signals that are sampled or driven every cycle.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset the direction register reads 0xFF (every pin an input) and the latch reads 0x00. In single-chip mode, `pad_oe` is then 0x00.
- R2: For a pin in ordinary I/O use, a direction bit of 0 drives the latch bit onto `pad_out` with `pad_oe` high. A direction bit of 1 makes `pad_oe` low. Each pin is set independently.
- R3: A write to address 0 (pin register) or address 1 (latch register) loads `reg_wdata` into the output latch. The new value appears on the following cycle.
- R4: A read at address 1 returns the latch contents, whatever level the pins have. A read at address 2 returns the direction register.
- R5: A read at address 0 returns `pad_in` as sampled through two flops. A change on a pin shows after the second rising edge and not after the first.
- R6: When `mode` is 1 (external-processor) or 2 (external-memory single-chip) and `bus_off` is 0, `pad_out` equals `ext_bus_out` and every `pad_oe` bit equals `ext_bus_oe`. The direction register has no effect in this state.
- R7: Setting `bus_off` to 1 in either external-memory mode hands all pins back to the register-controlled function.
- R8: When `mode` is 0 (single-chip) and `psp_en` is 1, pins 0 to 2 have `pad_oe` forced low. `psp_ctl` then carries their synchronized levels. In every other case `psp_ctl` is all ones, and `psp_en` has no effect outside mode 0.
- R9: When `mode` is 0 and `ccp_alt_n` is 0, pin 7 outputs `ccp_out`, while its output enable still follows direction bit 7. Otherwise pin 7 outputs latch bit 7.
- R10: The external bus takes precedence over the slave-port strobes and the timer pin when both are requested.
- R11: A write to address 3 changes neither register, and a read at address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 pins, 1 latch, 2 direction, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| mode | input | 2 | 0 single-chip, 1 external-processor, 2 external-memory single-chip, 3 treated as 0 |
| bus_off | input | 1 | Memory-controller bit that releases the pins from the external bus |
| psp_en | input | 1 | Parallel-slave-port enable |
| ccp_alt_n | input | 1 | Configuration bit, 0 routes the timer output to pin 7 |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Output values to the pads |
| pad_oe | output | 8 | Output enables to the pads, 1 drives |
| ext_bus_out | input | 8 | Address/data high byte from the memory controller |
| ext_bus_oe | input | 1 | Memory controller drive enable |
| ext_bus_in | output | 8 | Synchronized pin levels to the memory controller |
| psp_ctl | output | 3 | Synchronized slave-port strobes from pins 0..2, all ones when idle |
| ccp_out | input | 1 | Timer compare/PWM output |
| ccp_in | output | 1 | Synchronized pin 7 level to the timer |

## Verification
The bench checks the corner cases where ownership overlaps, each chosen so that a specific wrong design would fail it. With the bus, slave-port and timer functions all requested together, a design that ranked them in the wrong order would let the latch or `ccp_out` leak onto the bus byte. With pin 7 held by the timer, a design that took the enable from the timer would ignore direction bit 7. The bench also samples the pin register after exactly one edge and again after two: a design with one synchronizer stage too many or too few would return the new level a cycle early or late. Finally, the bench reads the latch while the pins carry a different value, and writes to the unused address, so a design that read the latch back from the pins, or decoded addresses loosely, would return the wrong byte.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXTPROC = 2'b01,
    MODE_EXTMEM = 2'b10,
    MODE_RSVD = 2'b11
  } op_mode_e;

  localparam logic [1:0] ADDR_PINS = 2'd0;
  localparam logic [1:0] ADDR_LATCH = 2'd1;
  localparam logic [1:0] ADDR_DIR = 2'd2;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] lat_q,
  output logic [WIDTH-1:0] dir_q
);
  import gpio_port_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else if (we) begin
      // both the pin and latch addresses land in the output latch
      if (addr == ADDR_PINS || addr == ADDR_LATCH) lat_q <= wdata;
      if (addr == ADDR_DIR) dir_q <= wdata;
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_owner.sv
module gpio_owner #(
  parameter int WIDTH = 8,
  parameter int PSP_PINS = 3,
  parameter int ALT_PIN = 7
) (
  input  logic             bus_own,
  input  logic             psp_act,
  input  logic             alt_act,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] ext_out,
  input  logic             ext_oe,
  input  logic             alt_out,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      if (i < PSP_PINS) begin : g_strobe
        always_comb begin
          if (bus_own) begin
            pad_out[i] = ext_out[i];
            pad_oe[i] = ext_oe;
          end else if (psp_act) begin
            pad_out[i] = lat_q[i];
            pad_oe[i] = 1'b0;
          end else begin
            pad_out[i] = lat_q[i];
            pad_oe[i] = ~dir_q[i];
          end
        end
      end else if (i == ALT_PIN) begin : g_alt
        always_comb begin
          if (bus_own) begin
            pad_out[i] = ext_out[i];
            pad_oe[i] = ext_oe;
          end else begin
            pad_out[i] = alt_act ? alt_out : lat_q[i];
            pad_oe[i] = ~dir_q[i];
          end
        end
      end else begin : g_plain
        always_comb begin
          if (bus_own) begin
            pad_out[i] = ext_out[i];
            pad_oe[i] = ext_oe;
          end else begin
            pad_out[i] = lat_q[i];
            pad_oe[i] = ~dir_q[i];
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int WIDTH = 8,
  parameter int PSP_PINS = 3,
  parameter int ALT_PIN = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [WIDTH-1:0]    reg_wdata,
  output logic [WIDTH-1:0]    reg_rdata,
  input  logic [1:0]          mode,
  input  logic                bus_off,
  input  logic                psp_en,
  input  logic                ccp_alt_n,
  input  logic [WIDTH-1:0]    pad_in,
  output logic [WIDTH-1:0]    pad_out,
  output logic [WIDTH-1:0]    pad_oe,
  input  logic [WIDTH-1:0]    ext_bus_out,
  input  logic                ext_bus_oe,
  output logic [WIDTH-1:0]    ext_bus_in,
  output logic [PSP_PINS-1:0] psp_ctl,
  input  logic                ccp_out,
  output logic                ccp_in
);
  import gpio_port_pkg::*;

  logic [WIDTH-1:0] lat_q, dir_q, pin_sync;
  logic bus_own, psp_act, alt_act, single_chip;
  op_mode_e mode_e;

  assign mode_e = op_mode_e'(mode);
  assign single_chip = (mode_e == MODE_SINGLE) || (mode_e == MODE_RSVD);
  assign bus_own = (mode_e == MODE_EXTPROC || mode_e == MODE_EXTMEM) && !bus_off;
  assign psp_act = single_chip && psp_en;
  assign alt_act = single_chip && !ccp_alt_n;

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .lat_q(lat_q), .dir_q(dir_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
  );

  gpio_owner #(.WIDTH(WIDTH), .PSP_PINS(PSP_PINS), .ALT_PIN(ALT_PIN)) u_owner (
    .bus_own(bus_own), .psp_act(psp_act), .alt_act(alt_act),
    .lat_q(lat_q), .dir_q(dir_q), .ext_out(ext_bus_out), .ext_oe(ext_bus_oe),
    .alt_out(ccp_out), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always_comb begin
    case (reg_addr)
      ADDR_PINS:  reg_rdata = pin_sync;
      ADDR_LATCH: reg_rdata = lat_q;
      ADDR_DIR:   reg_rdata = dir_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign ext_bus_in = pin_sync;
  assign psp_ctl = psp_act ? pin_sync[PSP_PINS-1:0] : '1;
  assign ccp_in = pin_sync[ALT_PIN];
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int WIDTH = 8,
  parameter int PSP_PINS = 3,
  parameter int ALT_PIN = 7,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [WIDTH-1:0] reg_wdata,
  input logic [1:0]       mode,
  input logic             bus_off,
  input logic             psp_en,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] ext_bus_out,
  input logic             ext_bus_oe,
  input logic [WIDTH-1:0] lat_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] pin_sync
);
  logic [1:0] warm;
  logic ext_mode;

  assign ext_mode = (mode == 2'd1) || (mode == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R3
  p_latch_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == 2'd0 || reg_addr == 2'd1)) |=> (lat_q == $past(reg_wdata)));

  // R11
  p_unused_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3) |=> ($stable(lat_q) && $stable(dir_q)));

  // R6 and R10
  p_bus_owns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !bus_off) |-> (pad_out == ext_bus_out && pad_oe == {WIDTH{ext_bus_oe}}));

  // R8
  p_strobe_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd0 || mode == 2'd3) && psp_en) |-> (pad_oe[PSP_PINS-1:0] == '0));

  // R2
  p_dir_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_mode && !bus_off) |->
      (pad_oe[ALT_PIN-1:PSP_PINS] == ~dir_q[ALT_PIN-1:PSP_PINS]));

  // R5
  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (pin_sync == $past(pad_in, 2)));
    end
  endgenerate
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
  .WIDTH(WIDTH), .PSP_PINS(PSP_PINS), .ALT_PIN(ALT_PIN), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mode(mode), .bus_off(bus_off), .psp_en(psp_en),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .ext_bus_out(ext_bus_out), .ext_bus_oe(ext_bus_oe),
  .lat_q(lat_q), .dir_q(dir_q), .pin_sync(pin_sync)
);

// File: tb/tb_gpio_mux_port.sv
module tb_gpio_mux_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] mode = 2'd0;
  logic bus_off = 1'b0;
  logic psp_en = 1'b0;
  logic ccp_alt_n = 1'b1;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe;
  logic [7:0] ext_bus_out = 8'h00;
  logic ext_bus_oe = 1'b0;
  logic [7:0] ext_bus_in;
  logic [2:0] psp_ctl;
  logic ccp_out = 1'b0;
  logic ccp_in;

  always #4 clk = ~clk;

  gpio_mux_port dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode(mode),
    .bus_off(bus_off), .psp_en(psp_en), .ccp_alt_n(ccp_alt_n),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .ext_bus_out(ext_bus_out), .ext_bus_oe(ext_bus_oe), .ext_bus_in(ext_bus_in),
    .psp_ctl(psp_ctl), .ccp_out(ccp_out), .ccp_in(ccp_in)
  );

  // observation selectors
  localparam int OBS_RDATA = 0;
  localparam int OBS_OUT = 1;
  localparam int OBS_OE = 2;
  localparam int OBS_PSP = 3;

  typedef struct {
    int sel;
    logic [7:0] exp;
    string req;
  } item_t;

  item_t sb[$];
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  function automatic logic [7:0] observe(int sel);
    case (sel)
      OBS_RDATA: return reg_rdata;
      OBS_OUT:   return pad_out;
      OBS_OE:    return pad_oe;
      default:   return {5'b0, psp_ctl};
    endcase
  endfunction

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sb.pop_front();
        act = observe(it.sel);
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: sel %0d actual %02h expected %02h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic push(int sel, logic [7:0] exp, string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic expect_read(logic [1:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    reg_addr = a;
    settle();
    push(OBS_RDATA, exp, req);
  endtask

  task automatic expect_pad(logic [7:0] out_e, logic [7:0] oe_e, string req);
    settle();
    push(OBS_OUT, out_e, req);
    push(OBS_OE, oe_e, req);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset defaults
    expect_read(2'd2, 8'hFF, "R1");
    expect_read(2'd1, 8'h00, "R1");
    settle(); push(OBS_OE, 8'h00, "R1");

    // R2 direction and latch drive
    reg_write(2'd2, 8'h03);
    reg_write(2'd1, 8'hA5);
    expect_pad(8'hA5, 8'hFC, "R2");
    expect_read(2'd1, 8'hA5, "R4");

    // R3 write through the pin address
    reg_write(2'd0, 8'h3C);
    expect_read(2'd1, 8'h3C, "R3");

    // R4 latch readback differs from the pins; R5 two-edge latency
    @(negedge clk); reg_addr = 2'd0; pad_in = 8'h5A;
    @(posedge clk); #1; push(OBS_RDATA, 8'h00, "R5");
    @(posedge clk); #1; push(OBS_RDATA, 8'h5A, "R5");
    expect_read(2'd1, 8'h3C, "R4");
    expect_read(2'd2, 8'h03, "R4");

    // R11 unused address
    reg_write(2'd3, 8'hFF);
    expect_read(2'd1, 8'h3C, "R11");
    expect_read(2'd2, 8'h03, "R11");
    expect_read(2'd3, 8'h00, "R11");

    // R6 external bus owns the pins
    @(negedge clk); mode = 2'd2; bus_off = 1'b0; ext_bus_out = 8'h96; ext_bus_oe = 1'b1;
    expect_pad(8'h96, 8'hFF, "R6");
    @(negedge clk); ext_bus_oe = 1'b0;
    expect_pad(8'h96, 8'h00, "R6");

    // R7 bus released
    @(negedge clk); bus_off = 1'b1;
    expect_pad(8'h3C, 8'hFC, "R7");

    // R10 bus beats strobes and timer pin
    @(negedge clk); mode = 2'd1; bus_off = 1'b0; psp_en = 1'b1;
    ccp_alt_n = 1'b0; ccp_out = 1'b1; ext_bus_oe = 1'b1; ext_bus_out = 8'h69;
    expect_pad(8'h69, 8'hFF, "R10");

    // R8 slave-port enable ignored outside single-chip mode
    reg_write(2'd2, 8'h00);
    @(negedge clk); mode = 2'd2; bus_off = 1'b1; ccp_alt_n = 1'b1;
    expect_pad(8'h3C, 8'hFF, "R8");
    settle(); push(OBS_PSP, 8'h07, "R8");

    // R8 strobes in single-chip mode
    @(negedge clk); mode = 2'd0; pad_in = 8'h05;
    expect_pad(8'h3C, 8'hF8, "R8");
    settle(); push(OBS_PSP, 8'h05, "R8");
    @(negedge clk); psp_en = 1'b0;
    settle(); push(OBS_PSP, 8'h07, "R8");

    // R9 timer pin: value from timer, enable from direction bit 7
    @(negedge clk); ccp_alt_n = 1'b0; ccp_out = 1'b1;
    expect_pad(8'hBC, 8'hFF, "R9");
    @(negedge clk); ccp_out = 1'b0;
    expect_pad(8'h3C, 8'hFF, "R9");
    @(negedge clk); ccp_alt_n = 1'b1; ccp_out = 1'b1;
    expect_pad(8'h3C, 8'hFF, "R9");
    reg_write(2'd2, 8'h80);
    @(negedge clk); ccp_alt_n = 1'b0;
    expect_pad(8'hBC, 8'h7F, "R9");

    @(negedge clk); @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule